// File: doc/BRIEF.md
# Primary Start Arbiter with Frequency Ramp

This block sits on the primary side of an isolated converter. It decides who drives the power switch after power-up, after a line fault or after an auto-restart. On every restart it holds the switch off for a listening period. During that period it watches a strobe that signals a request from the secondary controller. If two requests arrive with a spacing inside a configured window, the secondary is taken to be in charge and the block follows its requests. If the listening period ends without such a pair, the block switches on its own. Its switching period starts long and shortens step by step to the target period, and the current limit stays at its reduced setting.

While the block follows the secondary, a request that lands in a band of elapsed time after the last conduction is dropped. The band covers the audible resonant range, so no switching happens there. Every time value is a parameter counted in strobes of `tick_i`, so the time base can be scaled. The defaults assume a 1 µs tick: an 82 ms listening period, a 27–33 ms spacing window, a 10-tick target period (100 kHz) and an 83–143 tick skip band.

Top module: `start_arbiter`

## Requirements
- R1: During reset, and in the cycle after a restart, `mode_o` is 0 (listening), `gate_o` and `ilim_sel_o` are low and `period_o` equals PERIOD_START.
- R2: While listening, `gate_o` stays low. If no valid request pair is seen, the edge that samples the WAIT_TICKS-th tick since listening began moves `mode_o` to 2 (self-driven). The self-driven mode is entered only from listening.
- R3: While listening, a request whose gap from the previous request lies within SPACE_MIN..SPACE_MAX inclusive moves `mode_o` to 1 (follower) at that edge and loads `period_o` with PERIOD_TARGET. The gap is the number of ticks in the cycles after the previous request and before this one. A valid pair wins over expiry of the listening period.
- R4: A request whose gap lies outside the window does not change the mode. It becomes the new first request of the pattern.
- R5: `ilim_sel_o` is high, selecting the reduced current limit, exactly while `mode_o` is 2.
- R6: In mode 2 the ticks are counted from 0. The edge that samples the tick completing `period_o` ticks raises `gate_o` for one cycle, restarts the count and lowers `period_o` by PERIOD_STEP, with a floor of PERIOD_TARGET. `period_o` never rises while in mode 2.
- R7: A request in mode 2 moves `mode_o` to 1 at that edge and raises no gate pulse.
- R8: In mode 1, a request raises `gate_o` for one cycle after its edge, unless the tick count since the last gate pulse lies within BAND_LO..BAND_HI inclusive, in which case it is dropped. That count runs from the cycle in which `gate_o` was high up to the cycle before the request. `gate_o` is high in mode 1 only after a request.
- R9: `restart_i` returns the block to listening from any mode with all counters cleared. It takes priority over a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base strobe, one cycle wide |
| req_i | input | 1 | Secondary request strobe, one cycle wide |
| restart_i | input | 1 | Restart event (power-up, line fault, auto-restart) |
| mode_o | output | 2 | 0 listening, 1 follower, 2 self-driven |
| gate_o | output | 1 | One-cycle gate enable pulse for the power switch |
| ilim_sel_o | output | 1 | High selects the reduced start-up current limit |
| period_o | output | PER_W | Current self-driven switching period in ticks |

## Verification
The listening logic is driven with pairs spaced exactly at the window minimum and maximum, one tick beyond each edge, and with a short gap followed by a valid one. These patterns separate an inclusive window from an exclusive one and show that the pattern restarts from the second request. Silent listening periods, at full and at half tick rate, check the expiry count and the shape of the ramp: the number of gate pulses in a fixed span and the settled period. In follower mode, requests are placed at tick counts just below, on both edges of and just above the skip band. Restarts are issued in mid-ramp and together with a request.

// File: rtl/start_arb_pkg.sv
package start_arb_pkg;

    typedef enum logic [1:0] {
        MODE_LISTEN = 2'd0,
        MODE_FOLLOW = 2'd1,
        MODE_SOFT   = 2'd2
    } sa_mode_e;

    typedef struct packed {
        sa_mode_e mode;
        logic     gate;
    } sa_top_s;

endpackage

// File: rtl/sa_listen.sv
module sa_listen #(
    parameter int WAIT_TICKS = 82000,
    parameter int SPACE_MIN  = 27000,
    parameter int SPACE_MAX  = 33000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic tick_i,
    input  logic req_i,
    output logic pair_o,
    output logic expire_o
);
    localparam int WW = $clog2(WAIT_TICKS + 1);
    localparam int GW = $clog2(SPACE_MAX + 2);

    typedef struct packed {
        logic [WW-1:0] wcnt;
        logic          have;
        logic [GW-1:0] gap;
    } lst_s;

    lst_s st_q, st_d;
    logic in_win;
    logic last_tick;

    always_comb begin
        in_win    = (st_q.gap >= GW'(SPACE_MIN)) && (st_q.gap <= GW'(SPACE_MAX));
        last_tick = (st_q.wcnt == WW'(WAIT_TICKS - 1));
        pair_o    = active_i && req_i && st_q.have && in_win;
        expire_o  = active_i && tick_i && last_tick;
        st_d      = st_q;
        if (!active_i) begin
            st_d = '0;
        end else begin
            if (req_i) begin
                st_d.have = 1'b1;
                st_d.gap  = '0;
            end else if (tick_i && st_q.have && (st_q.gap <= GW'(SPACE_MAX))) begin
                st_d.gap = st_q.gap + 1'b1;
            end
            if (tick_i && !last_tick) begin
                st_d.wcnt = st_q.wcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sa_ramp.sv
module sa_ramp #(
    parameter int PERIOD_START  = 40,
    parameter int PERIOD_TARGET = 10,
    parameter int PERIOD_STEP   = 1,
    localparam int PER_W = $clog2(PERIOD_START + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_start_i,
    input  logic             load_target_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic [PER_W-1:0] period_o,
    output logic             fire_o
);
    typedef struct packed {
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] cnt;
    } rmp_s;

    rmp_s st_q, st_d;

    always_comb begin
        period_o = st_q.per;
        fire_o   = run_i && tick_i && (st_q.cnt == st_q.per - 1'b1);
        st_d     = st_q;
        if (load_start_i) begin
            st_d.per = PER_W'(PERIOD_START);
            st_d.cnt = '0;
        end else if (load_target_i) begin
            st_d.per = PER_W'(PERIOD_TARGET);
            st_d.cnt = '0;
        end else if (run_i && tick_i) begin
            if (fire_o) begin
                st_d.cnt = '0;
                if (32'(st_q.per) >= PERIOD_TARGET + PERIOD_STEP)
                    st_d.per = st_q.per - PER_W'(PERIOD_STEP);
                else
                    st_d.per = PER_W'(PERIOD_TARGET);
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.per <= PER_W'(PERIOD_START);
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sa_band.sv
module sa_band #(
    parameter int BAND_LO = 83,
    parameter int BAND_HI = 143
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic gate_i,
    input  logic tick_i,
    output logic in_band_o
);
    localparam int SW = $clog2(BAND_HI + 2);

    logic [SW-1:0] since_q, since_d;

    always_comb begin
        in_band_o = (since_q >= SW'(BAND_LO)) && (since_q <= SW'(BAND_HI));
        since_d   = since_q;
        if (restart_i)
            since_d = SW'(BAND_HI + 1);
        else if (gate_i)
            since_d = '0;
        else if (tick_i && (since_q <= SW'(BAND_HI)))
            since_d = since_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_q <= SW'(BAND_HI + 1);
        else        since_q <= since_d;
    end
endmodule

// File: rtl/start_arbiter.sv
module start_arbiter
    import start_arb_pkg::*;
#(
    parameter int WAIT_TICKS    = 82000,
    parameter int SPACE_MIN     = 27000,
    parameter int SPACE_MAX     = 33000,
    parameter int PERIOD_START  = 40,
    parameter int PERIOD_TARGET = 10,
    parameter int PERIOD_STEP   = 1,
    parameter int BAND_LO       = 83,
    parameter int BAND_HI       = 143,
    localparam int PER_W = $clog2(PERIOD_START + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             req_i,
    input  logic             restart_i,
    output logic [1:0]       mode_o,
    output logic             gate_o,
    output logic             ilim_sel_o,
    output logic [PER_W-1:0] period_o
);
    sa_top_s st_q, st_d;

    logic listen_act, pair, expire;
    logic load_start, load_target, ramp_run, fire;
    logic in_band;

    always_comb begin
        listen_act  = (st_q.mode == MODE_LISTEN) && !restart_i;
        load_start  = restart_i || (listen_act && expire && !pair);
        load_target = !restart_i && (pair || ((st_q.mode == MODE_SOFT) && req_i));
        ramp_run    = (st_q.mode == MODE_SOFT) && !req_i && !restart_i;

        st_d      = st_q;
        st_d.gate = 1'b0;
        if (restart_i) begin
            st_d.mode = MODE_LISTEN;
        end else begin
            case (st_q.mode)
                MODE_LISTEN: begin
                    if (pair)        st_d.mode = MODE_FOLLOW;
                    else if (expire) st_d.mode = MODE_SOFT;
                end
                MODE_SOFT: begin
                    if (req_i)     st_d.mode = MODE_FOLLOW;
                    else if (fire) st_d.gate = 1'b1;
                end
                MODE_FOLLOW: begin
                    if (req_i && !in_band) st_d.gate = 1'b1;
                end
                default: st_d.mode = MODE_LISTEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_LISTEN;
            st_q.gate <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    sa_listen #(
        .WAIT_TICKS(WAIT_TICKS), .SPACE_MIN(SPACE_MIN), .SPACE_MAX(SPACE_MAX)
    ) u_listen (
        .clk(clk), .rst_n(rst_n), .active_i(listen_act), .tick_i(tick_i),
        .req_i(req_i), .pair_o(pair), .expire_o(expire)
    );

    sa_ramp #(
        .PERIOD_START(PERIOD_START), .PERIOD_TARGET(PERIOD_TARGET),
        .PERIOD_STEP(PERIOD_STEP)
    ) u_ramp (
        .clk(clk), .rst_n(rst_n), .load_start_i(load_start),
        .load_target_i(load_target), .run_i(ramp_run), .tick_i(tick_i),
        .period_o(period_o), .fire_o(fire)
    );

    sa_band #(
        .BAND_LO(BAND_LO), .BAND_HI(BAND_HI)
    ) u_band (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .gate_i(st_d.gate),
        .tick_i(tick_i), .in_band_o(in_band)
    );

    assign mode_o     = st_q.mode;
    assign gate_o     = st_q.gate;
    assign ilim_sel_o = (st_q.mode == MODE_SOFT);
endmodule

module start_arbiter_chk #(
    parameter int PERIOD_START  = 40,
    parameter int PERIOD_TARGET = 10,
    parameter int PER_W         = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             req_i,
    input logic             restart_i,
    input logic [1:0]       mode_o,
    input logic             gate_o,
    input logic             ilim_sel_o,
    input logic [PER_W-1:0] period_o
);
    AST_LISTEN_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n) (mode_o == 2'd0) |-> !gate_o); // R2
    AST_SOFT_FROM_LISTEN: assert property (@(posedge clk) disable iff (!rst_n) $rose(ilim_sel_o) |-> ($past(mode_o) == 2'd0)); // R2
    AST_FOLLOW_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (($past(mode_o) == 2'd0) && (mode_o == 2'd1)) |-> $past(req_i)); // R3
    AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (period_o >= PER_W'(PERIOD_TARGET)) && (period_o <= PER_W'(PERIOD_START))); // R6
    AST_RAMP_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n) ((mode_o == 2'd2) && ($past(mode_o) == 2'd2)) |-> (period_o <= $past(period_o))); // R6
    AST_FOLLOW_GATE_REQ: assert property (@(posedge clk) disable iff (!rst_n) (gate_o && (mode_o == 2'd1)) |-> $past(req_i)); // R8
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) restart_i |=> ((mode_o == 2'd0) && !gate_o && (period_o == PER_W'(PERIOD_START)))); // R9
    AST_TICK_KNOWN: assert property (@(posedge clk) disable iff (!rst_n) !$isunknown({tick_i, req_i, restart_i})); // R1
endmodule

bind start_arbiter start_arbiter_chk #(
    .PERIOD_START(PERIOD_START), .PERIOD_TARGET(PERIOD_TARGET), .PER_W(PER_W)
) u_chk (.*);

// File: tb/start_arbiter_tb.sv
`timescale 1ns/1ps
module start_arbiter_tb;
    localparam int WAIT = 60, SMIN = 20, SMAX = 28;
    localparam int PSTART = 12, PTGT = 4, PSTEP = 3, BLO = 5, BHI = 9;
    localparam int PW = $clog2(PSTART + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0, req_i = 1'b0, restart_i = 1'b0;
    logic [1:0] mode_o;
    logic gate_o, ilim_sel_o;
    logic [PW-1:0] period_o;

    always #10 clk = ~clk;

    start_arbiter #(
        .WAIT_TICKS(WAIT), .SPACE_MIN(SMIN), .SPACE_MAX(SMAX),
        .PERIOD_START(PSTART), .PERIOD_TARGET(PTGT), .PERIOD_STEP(PSTEP),
        .BAND_LO(BLO), .BAND_HI(BHI)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .req_i(req_i),
        .restart_i(restart_i), .mode_o(mode_o), .gate_o(gate_o),
        .ilim_sel_o(ilim_sel_o), .period_o(period_o)
    );

    int tests = 0, fails = 0;
    int div = 1, phase = 0;
    bit finished = 0;

    // behavioural reference model
    int m_mode = 0, wc = 0, hv = 0, gp = 0, per = PSTART, swc = 0, sn = BHI + 1, m_gate = 0;

    always @(posedge clk) begin
        int g;
        g = 0;
        if (!rst_n) begin
            m_mode = 0; wc = 0; hv = 0; gp = 0; per = PSTART; swc = 0; sn = BHI + 1;
        end else if (restart_i) begin
            m_mode = 0; wc = 0; hv = 0; gp = 0; per = PSTART; swc = 0; sn = BHI + 1;
        end else begin
            case (m_mode)
                0: begin
                    if (req_i && hv != 0 && gp >= SMIN && gp <= SMAX) begin
                        m_mode = 1; per = PTGT; swc = 0; wc = 0; hv = 0; gp = 0;
                    end else begin
                        if (req_i) begin hv = 1; gp = 0; end
                        else if (tick_i && hv != 0 && gp <= SMAX) gp++;
                        if (tick_i) begin
                            if (wc == WAIT - 1) begin
                                m_mode = 2; per = PSTART; swc = 0; wc = 0; hv = 0; gp = 0;
                            end else wc++;
                        end
                    end
                end
                2: begin
                    if (req_i) begin m_mode = 1; per = PTGT; swc = 0; end
                    else if (tick_i) begin
                        if (swc == per - 1) begin
                            g = 1; swc = 0;
                            per = (per - PSTEP < PTGT) ? PTGT : per - PSTEP;
                        end else swc++;
                    end
                end
                default: if (req_i && !(sn >= BLO && sn <= BHI)) g = 1;
            endcase
            if (g != 0) sn = 0;
            else if (tick_i && sn <= BHI) sn++;
        end
        m_gate = g;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk(int'(mode_o) == m_mode, "R3 model mode", int'(mode_o), m_mode);
        chk(int'(gate_o) == m_gate, "R8 model gate", int'(gate_o), m_gate);
        chk(int'(ilim_sel_o) == int'(m_mode == 2), "R5 model ilim", int'(ilim_sel_o), int'(m_mode == 2));
        chk(int'(period_o) == per, "R6 model period", int'(period_o), per);
    endtask

    task automatic step(input bit r, input bit rs);
        tick_i = ((phase % div) == 0);
        phase++;
        req_i = r;
        restart_i = rs;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        tests++; fails++;
        $display("FAIL watchdog R1 actual=0 expected=1");
        summary();
    end

    initial begin
        int gates;
        repeat (3) @(negedge clk);
        chk(mode_o == 2'd0, "R1 reset mode", mode_o, 0);
        chk(gate_o == 1'b0, "R1 reset gate", gate_o, 0);
        chk(ilim_sel_o == 1'b0, "R1 reset ilim", ilim_sel_o, 0);
        chk(int'(period_o) == PSTART, "R1 reset period", period_o, PSTART);
        rst_n = 1'b1;

        // silent listening period expires into self-driven mode
        idle(WAIT - 1);
        chk(mode_o == 2'd0, "R2 still listening", mode_o, 0);
        step(0, 0);
        chk(mode_o == 2'd2, "R2 expiry", mode_o, 2);
        chk(ilim_sel_o == 1'b1, "R5 reduced limit", ilim_sel_o, 1);

        // ramp: periods 12,9,6,4,4,4 -> six pulses in forty ticks
        gates = 0;
        for (int i = 0; i < 40; i++) begin
            step(0, 0);
            if (gate_o) gates++;
        end
        chk(gates == 6, "R6 pulse count", gates, 6);
        chk(int'(period_o) == PTGT, "R6 period floor", period_o, PTGT);

        // request in self-driven mode hands over
        step(1, 0);
        chk(mode_o == 2'd1, "R7 handover", mode_o, 1);
        chk(gate_o == 1'b0, "R7 no pulse", gate_o, 0);
        chk(ilim_sel_o == 1'b0, "R5 limit released", ilim_sel_o, 0);

        // skip band in follower mode
        idle(20); step(1, 0);
        chk(gate_o == 1'b1, "R8 out of band", gate_o, 1);
        idle(6); step(1, 0);
        chk(gate_o == 1'b0, "R8 inside band", gate_o, 0);
        idle(10); step(1, 0);
        chk(gate_o == 1'b1, "R8 above band", gate_o, 1);
        idle(2); step(1, 0);
        chk(gate_o == 1'b1, "R8 below band", gate_o, 1);
        idle(4); step(1, 0);
        chk(gate_o == 1'b1, "R8 just below low edge", gate_o, 1);
        idle(5); step(1, 0);
        chk(gate_o == 1'b0, "R8 low edge", gate_o, 0);
        idle(3); step(1, 0);
        chk(gate_o == 1'b0, "R8 high edge", gate_o, 0);
        step(1, 0);
        chk(gate_o == 1'b1, "R8 past high edge", gate_o, 1);

        // restart and a valid pair
        step(0, 1);
        chk(mode_o == 2'd0, "R9 restart mode", mode_o, 0);
        chk(int'(period_o) == PSTART, "R9 restart period", period_o, PSTART);
        step(1, 0); idle(24); step(1, 0);
        chk(mode_o == 2'd1, "R3 valid pair", mode_o, 1);
        chk(int'(period_o) == PTGT, "R3 target period", period_o, PTGT);

        // short gap restarts the pattern
        step(0, 1); step(1, 0); idle(10); step(1, 0);
        chk(mode_o == 2'd0, "R4 short gap", mode_o, 0);
        idle(24); step(1, 0);
        chk(mode_o == 2'd1, "R4 second as first", mode_o, 1);

        // window edges
        step(0, 1); step(1, 0); idle(SMIN); step(1, 0);
        chk(mode_o == 2'd1, "R3 min gap", mode_o, 1);
        step(0, 1); step(1, 0); idle(SMAX); step(1, 0);
        chk(mode_o == 2'd1, "R3 max gap", mode_o, 1);
        step(0, 1); step(1, 0); idle(SMAX + 1); step(1, 0);
        chk(mode_o == 2'd0, "R4 gap too long", mode_o, 0);
        idle(SMIN - 1); step(1, 0);
        chk(mode_o == 2'd0, "R4 gap too short", mode_o, 0);
        idle(40);
        chk(mode_o == 2'd2, "R2 expiry after bad pairs", mode_o, 2);

        // restart in mid-ramp
        idle(5); step(0, 1);
        chk(mode_o == 2'd0, "R9 restart from ramp", mode_o, 0);
        chk(ilim_sel_o == 1'b0, "R9 limit cleared", ilim_sel_o, 0);

        // half-rate time base
        div = 2; phase = 0;
        idle(2 * WAIT - 2);
        chk(mode_o == 2'd0, "R2 half rate listening", mode_o, 0);
        idle(2);
        chk(mode_o == 2'd2, "R2 half rate expiry", mode_o, 2);
        idle(30);
        step(1, 0);
        chk(mode_o == 2'd1, "R7 half rate handover", mode_o, 1);

        // restart beats a simultaneous request
        idle(30); step(1, 1);
        chk(mode_o == 2'd0, "R9 restart priority", mode_o, 0);
        chk(gate_o == 1'b0, "R9 no pulse on restart", gate_o, 0);
        idle(4);
        summary();
    end
endmodule